// File: doc/BRIEF.md
# Continuous Data Decoding Mode Controller

This block is the mode controller of a paging decoder that receives continuous data. Once per batch, at each expected sync position, an upstream matcher classifies the received code-word. It may be preamble, the standard sync word, an enabled continuous-data sync word with a 3-bit identifier, an enabled non-continuous sync word, or nothing recognised. The controller uses that class, an off request and a forced-termination command to move between idle, preamble-receive, data-receive, continuous-data and fade-recovery modes.

While in continuous-data mode the controller counts received code-words. At the first sync position after a threshold of code-words (16 by default), it raises a host interrupt and presents a 3-byte call header. The header holds the matched sync identifier, the two function bits of the address code-word and the detected error type. A forced termination ends continuous decoding with a terminator write. Every other exit is silent. The radio, error correction, storage and host bus sit outside this block.

Top module: `cdm_ctrl`

## Requirements
- R1: After reset, `mode` is 0 (idle), and `irq`, `irq_pend`, `hdr_vld` and `term_wr` are all low.
- R2: `off_req` moves `mode` to 0 (idle) at the next clock edge from any mode. It takes priority over every other input and never causes `term_wr`.
- R3: In idle, sync strobes have no effect on `mode`. `power_on` moves idle to preamble-receive (`mode`=1).
- R4: Outside continuous-data and idle, a sync strobe changes `mode` by class. Class 1 (preamble) gives `mode`=1. Class 2 (standard) or class 4 (non-continuous) gives data-receive, `mode`=2. Class 3 (continuous) gives continuous-data, `mode`=3, and latches `sync_id`. Class 0 and classes 5 to 7 leave `mode` unchanged. Fade-recovery is `mode`=4.
- R5: In continuous-data mode, a class 1 strobe leaves for `mode`=1 and a class 2 or 4 strobe leaves for `mode`=2, both without `term_wr`. Class 3, class 0 and classes 5 to 7 keep `mode`=3. The latched identifier is not replaced.
- R6: The code-word counter is cleared on every entry to continuous-data mode. It then counts `cw_stb` pulses, saturating at the threshold.
- R7: A sync strobe that keeps continuous-data mode, arriving when at least THRESH code-words have been counted, makes `irq` high for exactly one cycle after the strobe edge. This happens at most once per stay in continuous-data mode.
- R8: `irq_pend` rises together with `irq` and stays high until a cycle with `irq_ack` and no new `irq`.
- R9: `hdr_vld` pulses in the same cycle as `irq`. `hdr[23:16]` is {5'b0, latched identifier}, `hdr[15:8]` is {6'b0, `addr_fn`} and `hdr[7:0]` is {5'b0, error type}, all sampled at the triggering strobe.
- R10: When `concat` is high at the triggering strobe, bit 2 of the error type in `hdr[2]` is forced to 0.
- R11: `force_term` in continuous-data mode (without `off_req`) moves to fade-recovery (`mode`=4) and pulses `term_wr` for one cycle. It wins over a same-cycle sync strobe. In every other mode it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| power_on | input | 1 | Leave idle for preamble-receive |
| off_req | input | 1 | Switch decoder off (to idle) |
| sync_stb | input | 1 | One-cycle strobe at an expected sync position |
| sync_cls | input | 3 | Class of the sync-position code-word (0 none, 1 preamble, 2 standard, 3 continuous, 4 non-continuous) |
| sync_id | input | 3 | Identifier of a matched continuous-data sync word |
| cw_stb | input | 1 | One-cycle strobe per received code-word |
| force_term | input | 1 | Forced-termination command |
| addr_fn | input | 2 | Function bits of the address code-word |
| err_type | input | 3 | Detected error type |
| concat | input | 1 | Header is a concatenated call header |
| irq_ack | input | 1 | Host acknowledge of the interrupt |
| mode | output | 3 | Current mode (0 idle, 1 preamble, 2 data, 3 continuous, 4 fade) |
| irq | output | 1 | One-cycle interrupt pulse |
| irq_pend | output | 1 | Interrupt pending until acknowledged |
| hdr_vld | output | 1 | Header valid pulse |
| hdr | output | 24 | Three-byte call header |
| term_wr | output | 1 | Call terminator write pulse |

## Verification
The assertions assume that `sync_stb`, `cw_stb`, `force_term` and `irq_ack` arrive as pulses that last a single cycle. They also assume that an interrupt can only follow a strobe, so `irq` is never expected twice in a row. The bench raises each pulse input for one cycle inside its step task and clears it before the next step, and it draws `sync_cls` over all eight codes, including the unused 5 to 7. The random weights favour "none" and "continuous" classes, so that continuous-data mode lives long enough to cross the code-word threshold between exits.

// File: rtl/cdm_pkg.sv
// Package cdm_pkg: shared mode encoding and sync-class codes for the
// continuous data mode controller. Assumes the upstream matcher already
// priority-encodes its result into one of the class codes below.
package cdm_pkg;

    typedef enum logic [2:0] {
        MODE_IDLE = 3'd0,
        MODE_PRE  = 3'd1,
        MODE_DATA = 3'd2,
        MODE_CONT = 3'd3,
        MODE_FADE = 3'd4
    } cdm_mode_e;

    localparam logic [2:0] CLS_NONE = 3'd0;
    localparam logic [2:0] CLS_PRE  = 3'd1;
    localparam logic [2:0] CLS_STD  = 3'd2;
    localparam logic [2:0] CLS_CONT = 3'd3;
    localparam logic [2:0] CLS_NONC = 3'd4;

    localparam int HDR_BYTE_W = 8;
    localparam int HDR_BYTES  = 3;

endpackage

// File: rtl/cdm_mode_fsm.sv
// Module cdm_mode_fsm: mode state machine. Decides the next mode from the
// off request, forced termination and sync class, and flags entry into and
// sync-driven stays in continuous-data mode. Assumes sync_stb is one cycle.
module cdm_mode_fsm
    import cdm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       power_on,
    input  logic       off_req,
    input  logic       sync_stb,
    input  logic [2:0] sync_cls,
    input  logic       force_term,
    output cdm_mode_e  mode,
    output logic       enter_cont,
    output logic       stay_sync,
    output logic       term_wr
);

    cdm_mode_e nxt;
    logic      hit_pre;
    logic      hit_data;
    logic      hit_cont;

    // Decode the strobed class into the three events that move the mode.
    always_comb begin
        hit_pre  = sync_stb && (sync_cls == CLS_PRE);
        hit_data = sync_stb && ((sync_cls == CLS_STD) || (sync_cls == CLS_NONC));
        hit_cont = sync_stb && (sync_cls == CLS_CONT);
    end

    // Next-mode selection; off wins, then forced termination, then sync class.
    always_comb begin
        nxt = mode;
        if (off_req) begin
            nxt = MODE_IDLE;
        end else begin
            case (mode)
                MODE_IDLE: if (power_on) nxt = MODE_PRE;
                MODE_CONT: begin
                    if (force_term)    nxt = MODE_FADE;
                    else if (hit_pre)  nxt = MODE_PRE;
                    else if (hit_data) nxt = MODE_DATA;
                end
                MODE_PRE, MODE_DATA, MODE_FADE: begin
                    if (hit_pre)       nxt = MODE_PRE;
                    else if (hit_data) nxt = MODE_DATA;
                    else if (hit_cont) nxt = MODE_CONT;
                end
                default: nxt = MODE_IDLE;
            endcase
        end
    end

    // Entry and stay flags used by the counter and header builder.
    always_comb begin
        enter_cont = (nxt == MODE_CONT) && (mode != MODE_CONT);
        stay_sync  = sync_stb && (mode == MODE_CONT) && (nxt == MODE_CONT);
    end

    // Mode register and terminator pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode    <= MODE_IDLE;
            term_wr <= 1'b0;
        end else begin
            mode    <= nxt;
            term_wr <= !off_req && force_term && (mode == MODE_CONT);
        end
    end

endmodule

// File: rtl/cdm_cw_count.sv
// Module cdm_cw_count: counts code-words in continuous-data mode and fires
// the output trigger once per stay, at the first staying sync strobe after
// THRESH code-words. Assumes enter_cont and stay_sync come from the FSM.
module cdm_cw_count #(
    parameter int THRESH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_cont,
    input  logic enter_cont,
    input  logic cw_stb,
    input  logic stay_sync,
    output logic trig
);

    localparam int                CNT_W = $clog2(THRESH + 1);
    localparam logic [CNT_W-1:0]  LIMIT = CNT_W'(THRESH);

    logic [CNT_W-1:0] cnt;
    logic             started;

    // Trigger when the saturated count meets a staying sync for the first time.
    always_comb trig = stay_sync && (cnt == LIMIT) && !started;

    // Saturating code-word counter, cleared on entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (enter_cont) begin
            cnt <= '0;
        end else if (in_cont && cw_stb && (cnt != LIMIT)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // One-shot flag so output starts only once per continuous stay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started <= 1'b0;
        end else if (enter_cont) begin
            started <= 1'b0;
        end else if (trig) begin
            started <= 1'b1;
        end
    end

endmodule

// File: rtl/cdm_hdr_build.sv
// Module cdm_hdr_build: latches the continuous-data sync identifier on entry
// and assembles the three-byte call header on the trigger. Assumes ERR_W >= 2
// so that a top error bit exists to clear for concatenated headers.
module cdm_hdr_build
    import cdm_pkg::*;
#(
    parameter int ID_W  = 3,
    parameter int FN_W  = 2,
    parameter int ERR_W = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             enter_cont,
    input  logic [ID_W-1:0]                  sync_id,
    input  logic                             trig,
    input  logic [FN_W-1:0]                  addr_fn,
    input  logic [ERR_W-1:0]                 err_type,
    input  logic                             concat,
    output logic                             hdr_vld,
    output logic [HDR_BYTES*HDR_BYTE_W-1:0]  hdr
);

    localparam int HDR_W = HDR_BYTES * HDR_BYTE_W;

    logic [ID_W-1:0]  id_q;
    logic [ERR_W-1:0] err_eff;
    logic [HDR_W-1:0] hdr_nxt;

    // Error type with its top bit cleared for a concatenated header.
    always_comb begin
        err_eff          = err_type;
        err_eff[ERR_W-1] = err_type[ERR_W-1] & ~concat;
    end

    // Pack identifier, function bits and error type, one per byte.
    always_comb begin
        hdr_nxt = {{(HDR_BYTE_W-ID_W){1'b0}},  id_q,
                   {(HDR_BYTE_W-FN_W){1'b0}},  addr_fn,
                   {(HDR_BYTE_W-ERR_W){1'b0}}, err_eff};
    end

    // Identifier latch, loaded on entry to continuous-data mode.
    always_ff @(posedge clk) begin
        if (!rst_n)          id_q <= '0;
        else if (enter_cont) id_q <= sync_id;
    end

    // Header register and its valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr     <= '0;
            hdr_vld <= 1'b0;
        end else begin
            hdr_vld <= trig;
            if (trig) hdr <= hdr_nxt;
        end
    end

endmodule

// File: rtl/cdm_irq.sv
// Module cdm_irq: turns the trigger into a one-cycle interrupt pulse and a
// pending level held until the host acknowledges. A new trigger beats an ack.
module cdm_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic irq_ack,
    output logic irq,
    output logic irq_pend
);

    // Pulse and pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq      <= 1'b0;
            irq_pend <= 1'b0;
        end else begin
            irq <= trig;
            if (trig)         irq_pend <= 1'b1;
            else if (irq_ack) irq_pend <= 1'b0;
        end
    end

endmodule

// File: rtl/cdm_ctrl.sv
// Module cdm_ctrl: top of the continuous data mode controller. Wires the
// mode FSM, code-word counter, header builder and interrupt stage.
// Assumes all strobes are single-cycle and synchronous to clk.
module cdm_ctrl #(
    parameter int THRESH = 16,
    parameter int ID_W   = 3,
    parameter int FN_W   = 2,
    parameter int ERR_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              power_on,
    input  logic              off_req,
    input  logic              sync_stb,
    input  logic [2:0]        sync_cls,
    input  logic [ID_W-1:0]   sync_id,
    input  logic              cw_stb,
    input  logic              force_term,
    input  logic [FN_W-1:0]   addr_fn,
    input  logic [ERR_W-1:0]  err_type,
    input  logic              concat,
    input  logic              irq_ack,
    output logic [2:0]        mode,
    output logic              irq,
    output logic              irq_pend,
    output logic              hdr_vld,
    output logic [23:0]       hdr,
    output logic              term_wr
);

    import cdm_pkg::*;

    cdm_mode_e mode_q;
    logic      enter_cont;
    logic      stay_sync;
    logic      trig;
    logic      in_cont;

    // Export the mode and flag the continuous state for the counter.
    always_comb begin
        mode    = mode_q;
        in_cont = (mode_q == MODE_CONT);
    end

    cdm_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .power_on   (power_on),
        .off_req    (off_req),
        .sync_stb   (sync_stb),
        .sync_cls   (sync_cls),
        .force_term (force_term),
        .mode       (mode_q),
        .enter_cont (enter_cont),
        .stay_sync  (stay_sync),
        .term_wr    (term_wr)
    );

    cdm_cw_count #(.THRESH(THRESH)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_cont    (in_cont),
        .enter_cont (enter_cont),
        .cw_stb     (cw_stb),
        .stay_sync  (stay_sync),
        .trig       (trig)
    );

    cdm_hdr_build #(.ID_W(ID_W), .FN_W(FN_W), .ERR_W(ERR_W)) u_hdr (
        .clk        (clk),
        .rst_n      (rst_n),
        .enter_cont (enter_cont),
        .sync_id    (sync_id),
        .trig       (trig),
        .addr_fn    (addr_fn),
        .err_type   (err_type),
        .concat     (concat),
        .hdr_vld    (hdr_vld),
        .hdr        (hdr)
    );

    cdm_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (trig),
        .irq_ack  (irq_ack),
        .irq      (irq),
        .irq_pend (irq_pend)
    );

endmodule

// File: rtl/cdm_ctrl_chk.sv
// Module cdm_ctrl_chk: property checker bound to cdm_ctrl. Relates the
// top-level inputs and outputs over time; assumes single-cycle strobes.
module cdm_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       off_req,
    input logic       force_term,
    input logic       sync_stb,
    input logic       irq_ack,
    input logic [2:0] mode,
    input logic       irq,
    input logic       irq_pend,
    input logic       hdr_vld,
    input logic       term_wr
);

    assert_off_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        off_req |=> (mode == 3'd0));

    assert_off_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        off_req |=> !term_wr);

    assert_mode_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mode <= 3'd4);

    assert_irq_after_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(sync_stb));

    assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_pend_with_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_pend);

    assert_pend_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pend) |-> irq);

    assert_pend_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pend && !irq_ack) |=> irq_pend);

    assert_hdr_with_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_vld == irq);

    assert_term_fade_R11: assert property (@(posedge clk) disable iff (!rst_n)
        term_wr |-> (mode == 3'd4));

    assert_term_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        term_wr |-> $past(force_term));

endmodule

bind cdm_ctrl cdm_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .off_req    (off_req),
    .force_term (force_term),
    .sync_stb   (sync_stb),
    .irq_ack    (irq_ack),
    .mode       (mode),
    .irq        (irq),
    .irq_pend   (irq_pend),
    .hdr_vld    (hdr_vld),
    .term_wr    (term_wr)
);

// File: tb/tb_cdm_ctrl.sv
// Bench for cdm_ctrl: directed corner cases, then seeded random stimulus,
// all compared against a bench-side model of the requirements.
module tb_cdm_ctrl;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        power_on = 0, off_req = 0, sync_stb = 0, cw_stb = 0;
    logic        force_term = 0, concat = 0, irq_ack = 0;
    logic [2:0]  sync_cls = 0, sync_id = 0, err_type = 0;
    logic [1:0]  addr_fn = 0;
    logic [2:0]  mode;
    logic        irq, irq_pend, hdr_vld, term_wr;
    logic [23:0] hdr;

    cdm_ctrl dut (.*);

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // Model state
    int          m_mode = 0, m_cnt = 0;
    bit          m_started = 0, m_irq = 0, m_pend = 0, m_hv = 0, m_term = 0;
    logic [2:0]  m_id = 0;
    logic [23:0] m_hdr = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int next_mode(int cur);
        bit pre, dat, con;
        pre = sync_stb && sync_cls == 3'd1;
        dat = sync_stb && (sync_cls == 3'd2 || sync_cls == 3'd4);
        con = sync_stb && sync_cls == 3'd3;
        if (off_req) return 0;
        case (cur)
            0: return power_on ? 1 : 0;
            3: return force_term ? 4 : pre ? 1 : dat ? 2 : 3;
            default: return pre ? 1 : dat ? 2 : con ? 3 : cur;
        endcase
    endfunction

    function automatic logic [23:0] make_hdr(logic [2:0] id, logic [1:0] fn,
                                             logic [2:0] err, bit cat);
        logic [2:0] e;
        e = err;
        if (cat) e[2] = 1'b0;
        return {5'b0, id, 6'b0, fn, 5'b0, e};
    endfunction

    // One clock: update model from current inputs, clock, compare, clear pulses.
    task automatic step();
        int  nm;
        bit  trig;
        nm   = next_mode(m_mode);
        trig = (m_mode == 3) && (nm == 3) && sync_stb && m_cnt >= 16 && !m_started;
        m_term = !off_req && force_term && m_mode == 3;
        if (nm == 3 && m_mode != 3) begin
            m_cnt = 0; m_started = 0; m_id = sync_id;
        end else if (m_mode == 3 && nm == 3 && cw_stb && m_cnt < 16) begin
            m_cnt++;
        end
        if (trig) begin
            m_started = 1;
            m_hdr = make_hdr(m_id, addr_fn, err_type, concat);
        end
        m_irq = trig; m_hv = trig;
        if (trig) m_pend = 1; else if (irq_ack) m_pend = 0;
        m_mode = nm;
        @(posedge clk); #1;
        chk("R5 mode", 32'(mode), 32'(m_mode));
        chk("R7 irq", 32'(irq), 32'(m_irq));
        chk("R8 irq_pend", 32'(irq_pend), 32'(m_pend));
        chk("R9 hdr_vld", 32'(hdr_vld), 32'(m_hv));
        if (hdr_vld) chk("R9 hdr", 32'(hdr), 32'(m_hdr));
        chk("R11 term_wr", 32'(term_wr), 32'(m_term));
        power_on = 0; off_req = 0; sync_stb = 0; cw_stb = 0;
        force_term = 0; irq_ack = 0;
    endtask

    task automatic sync(logic [2:0] cls, logic [2:0] id);
        sync_stb = 1; sync_cls = cls; sync_id = id; step();
    endtask

    task automatic cws(int n);
        for (int i = 0; i < n; i++) begin cw_stb = 1; step(); end
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        chk("R1 mode", 32'(mode), 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 irq_pend", 32'(irq_pend), 0);
        chk("R1 hdr_vld", 32'(hdr_vld), 0);
        chk("R1 term_wr", 32'(term_wr), 0);
        // R3 idle ignores sync, power_on leaves idle
        sync(3'd3, 3'd2); chk("R3 idle ignores sync", 32'(mode), 0);
        power_on = 1; step(); chk("R3 power_on", 32'(mode), 1);
        // R4 transitions
        sync(3'd6, 3'd0); chk("R4 unused class", 32'(mode), 1);
        sync(3'd2, 3'd0); chk("R4 standard", 32'(mode), 2);
        sync(3'd3, 3'd5); chk("R4 continuous", 32'(mode), 3);
        // R6 boundary: 15 code-words then sync gives no irq
        cws(15);
        sync(3'd0, 3'd0); chk("R6 below threshold", 32'(irq), 0);
        cws(1);
        addr_fn = 2'd2; err_type = 3'd7; concat = 1;
        sync(3'd3, 3'd1);
        chk("R7 irq at threshold", 32'(irq), 1);
        chk("R9 R10 header", 32'(hdr), 24'h050203);
        chk("R8 pend", 32'(irq_pend), 1);
        step(); chk("R7 single pulse", 32'(irq), 0);
        step(); chk("R8 held", 32'(irq_pend), 1);
        irq_ack = 1; step(); chk("R8 ack", 32'(irq_pend), 0);
        concat = 0;
        cws(20);
        sync(3'd0, 3'd0); chk("R7 once per stay", 32'(irq), 0);
        // R11 forced termination beats sync
        force_term = 1; sync_stb = 1; sync_cls = 3'd1; step();
        chk("R11 fade", 32'(mode), 4);
        chk("R11 term pulse", 32'(term_wr), 1);
        force_term = 1; step();
        chk("R11 ignored outside", 32'(mode), 4);
        chk("R11 no term outside", 32'(term_wr), 0);
        // R5 silent exit by preamble
        sync(3'd3, 3'd1);
        sync(3'd1, 3'd0);
        chk("R5 exit preamble", 32'(mode), 1);
        chk("R5 silent", 32'(term_wr), 0);
        // R6 counter cleared on re-entry
        sync(3'd3, 3'd4); cws(10);
        sync(3'd4, 3'd0); chk("R5 exit noncont", 32'(mode), 2);
        sync(3'd3, 3'd4); cws(10);
        sync(3'd0, 3'd0); chk("R6 cleared on entry", 32'(irq), 0);
        // R2 off from continuous, priority over power_on
        cws(5);
        off_req = 1; force_term = 1; step();
        chk("R2 off to idle", 32'(mode), 0);
        chk("R2 off silent", 32'(term_wr), 0);
        off_req = 1; power_on = 1; step();
        chk("R2 off priority", 32'(mode), 0);
        // Random phase
        void'($urandom(32'd20240611));
        for (int c = 0; c < 6000; c++) begin
            int r;
            r = $urandom_range(0, 99);
            sync_stb   = ($urandom_range(0, 5) == 0);
            r          = $urandom_range(0, 15);
            sync_cls   = (r < 6) ? 3'd0 : (r < 12) ? 3'd3 : 3'($urandom_range(0, 7));
            sync_id    = 3'($urandom());
            cw_stb     = $urandom_range(0, 1) == 1;
            off_req    = ($urandom_range(0, 399) == 0);
            force_term = ($urandom_range(0, 249) == 0);
            power_on   = ($urandom_range(0, 9) == 0);
            irq_ack    = ($urandom_range(0, 19) == 0);
            addr_fn    = 2'($urandom());
            err_type   = 3'($urandom());
            concat     = $urandom_range(0, 1) == 1;
            step();
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule